// File: doc/BRIEF.md
# USB Full/Low-Speed Line Interface with Eye-Pattern Generator

This block connects a USB serial interface engine to an external full-speed or low-speed transceiver. On the transmit side it passes the engine's requested D+/D- levels and drive request to the transceiver pins `pad_vpo`/`pad_vmo`. It also drives an active-low output enable `pad_oe_n`. On the receive side it passes the transceiver's single-ended inputs through a two-flop synchronizer. It then decodes them into a two-bit line state for the engine.

A monitor output reports whether the interface is driving the bus or listening. It is active when an external transceiver is selected or when a force bit is set. When the interface is enabled and the eye-test bit is set, the block takes over the transmit pins. It asserts output enable and sends an endless alternation of J and K symbols, one per bit-rate pulse, for board-level signal-integrity measurement. The first symbol depends on bus speed. The speed that was configured when the test started stays in force until the test ends.

Top module: `usbfs_line_ctrl`

## Requirements
- R1: `pad_oe_n` is active low: it is 0 exactly when the bus is driven (eye test running, or `tx_drive_req`=1 with the test idle), and 1 otherwise.
- R2: While `eye_busy`=0, `pad_vpo`=`tx_dp_req`, `pad_vmo`=`tx_dm_req` and `pad_oe_n`=~`tx_drive_req` in the same cycle, with no register in the path.
- R3: `oe_mon`=1 only when the bus is driven and the monitor is enabled (`ext_xcvr`=1 or `mon_force`=1). With both of those at 0, `oe_mon` stays 0.
- R4: `line_state` encoding: 2'b00 single-ended zero (vp=0, vm=0), 2'b01 differential 0 (vp=0, vm=1), 2'b10 differential 1 (vp=1, vm=0), 2'b11 illegal (vp=1, vm=1).
- R5: `line_state` shows the inputs sampled two rising edges earlier, and resets to 2'b00.
- R6: On the first rising edge with `eye_en`=1 and `core_en`=1, `eye_busy` goes to 1 and `pad_oe_n` goes to 0. From then on the engine's transmit requests have no effect on the pins.
- R7: Symbol levels: at full speed J is (vpo=1, vmo=0) and K is (0, 1); at low speed J is (0, 1) and K is (1, 0). A full-speed test begins with K and a low-speed test begins with J.
- R8: While the test runs, every rising edge with `bit_tick`=1 flips the symbol. Edges without `bit_tick` hold it.
- R9: After `eye_en` (or `core_en`) drops, the current symbol holds until the next edge with `bit_tick`=1. On that edge `eye_busy` returns to 0 and pass-through (R2) resumes.
- R10: With `core_en`=0, `eye_en` has no effect: `eye_busy` stays 0 and the pins follow the engine.
- R11: The speed sampled when the test starts sets the symbol mapping for the whole run. Changes on `full_speed` during the run are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_en | input | 1 | Interface enable |
| full_speed | input | 1 | 1 = full speed, 0 = low speed |
| ext_xcvr | input | 1 | External transceiver selected (enables monitor) |
| mon_force | input | 1 | Forces the output-enable monitor on |
| eye_en | input | 1 | Eye-pattern test enable |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_dp_req | input | 1 | Engine's requested D+ level |
| tx_dm_req | input | 1 | Engine's requested D- level |
| tx_drive_req | input | 1 | Engine wants to drive the bus |
| rx_vp | input | 1 | Single-ended D+ from transceiver |
| rx_vm | input | 1 | Single-ended D- from transceiver |
| pad_vpo | output | 1 | D+ drive level to transceiver |
| pad_vmo | output | 1 | D- drive level to transceiver |
| pad_oe_n | output | 1 | Active-low transceiver output enable |
| oe_mon | output | 1 | Monitor: bus is being driven |
| eye_busy | output | 1 | Eye-pattern test running |
| line_state | output | 2 | Synchronized, decoded receive line state |

## Verification
Pass-through and the monitor are combinational, so their checks are taken in the same cycle, about 1 ns after the inputs change. Eye-test start, each toggle and the end all take effect on the rising edge where the enable or `bit_tick` is sampled. Their checks therefore fall just after that edge. `line_state` needs two edges, so each receive pattern is checked once after the first edge, where the old value must remain. It is checked again after the second edge, where the new value is due. Inputs always change 1 ns after a rising edge, so no sample depends on the order of processes at the edge.

// File: rtl/usbfs_line_pkg.sv
package usbfs_line_pkg;

    typedef enum logic [1:0] {
        LS_SE0     = 2'b00,
        LS_DIFF0   = 2'b01,
        LS_DIFF1   = 2'b10,
        LS_ILLEGAL = 2'b11
    } line_state_e;

    typedef struct packed {
        logic run;    // test pattern active
        logic sym_k;  // 1 = K symbol, 0 = J symbol
        logic fs;     // speed captured at start
    } eye_state_t;

    localparam eye_state_t EYE_RESET = '{run: 1'b0, sym_k: 1'b0, fs: 1'b0};

    function automatic line_state_e decode_line(input logic vp, input logic vm);
        line_state_e r;
        unique case ({vp, vm})
            2'b00:   r = LS_SE0;
            2'b01:   r = LS_DIFF0;
            2'b10:   r = LS_DIFF1;
            default: r = LS_ILLEGAL;
        endcase
        return r;
    endfunction

    // Returns {vpo, vmo} for a symbol at the given speed.
    function automatic logic [1:0] sym_pins(input logic fs, input logic sym_k);
        logic [1:0] j_lvl;
        j_lvl = fs ? 2'b10 : 2'b01;
        return sym_k ? ~j_lvl : j_lvl;
    endfunction

endpackage

// File: rtl/usbfs_rx_sync.sv
module usbfs_rx_sync
    import usbfs_line_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_vp,
    input  logic        rx_vm,
    output line_state_e line_state
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] vp;
        logic [STAGES-1:0] vm;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.vp = {sync_q.vp[STAGES-2:0], rx_vp};
        sync_d.vm = {sync_q.vm[STAGES-2:0], rx_vm};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign line_state = decode_line(sync_q.vp[LAST], sync_q.vm[LAST]);

    generate
        if (STAGES == 2) begin : g_lat_chk
            logic [1:0] warm_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)             warm_q <= 2'd0;
                else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
            end
            // R5: state reflects inputs from two edges earlier
            p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q >= 2'd2) |->
                (line_state == decode_line($past(rx_vp, 2), $past(rx_vm, 2))));
        end
    endgenerate

endmodule

// File: rtl/usbfs_eye_gen.sv
module usbfs_eye_gen
    import usbfs_line_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_en,
    input  logic eye_en,
    input  logic full_speed,
    input  logic bit_tick,
    output logic eye_active,
    output logic eye_vpo,
    output logic eye_vmo
);
    eye_state_t eye_d, eye_q;
    logic       go;

    assign go = eye_en & core_en;

    always_comb begin
        eye_d = eye_q;
        if (!eye_q.run) begin
            if (go) begin
                eye_d.run   = 1'b1;
                eye_d.fs    = full_speed;
                eye_d.sym_k = full_speed;   // FS opens with K, LS with J
            end
        end else if (bit_tick) begin
            if (go) eye_d.sym_k = ~eye_q.sym_k;
            else    eye_d.run   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eye_q <= EYE_RESET;
        else        eye_q <= eye_d;
    end

    assign eye_active         = eye_q.run;
    assign {eye_vpo, eye_vmo} = sym_pins(eye_q.fs, eye_q.sym_k);

    // R7: both speeds open on vpo=0, vmo=1
    p_first_sym_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eye_active) |-> (!eye_vpo && eye_vmo));

    // R6 / R10: start only when both enables were high
    p_start_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eye_active) |-> $past(eye_en && core_en));

    // R8: a bit pulse while running flips the symbol
    p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eye_active && $past(eye_active && bit_tick)) |-> (eye_vpo != $past(eye_vpo)));

    // R9: no change without a bit pulse
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eye_active) && !$past(bit_tick)) |->
        (eye_active && $stable(eye_vpo) && $stable(eye_vmo)));

endmodule

// File: rtl/usbfs_tx_mux.sv
module usbfs_tx_mux (
    input  logic eye_active,
    input  logic eye_vpo,
    input  logic eye_vmo,
    input  logic tx_dp_req,
    input  logic tx_dm_req,
    input  logic tx_drive_req,
    input  logic ext_xcvr,
    input  logic mon_force,
    output logic pad_vpo,
    output logic pad_vmo,
    output logic pad_oe_n,
    output logic oe_mon
);
    logic driving;
    logic mon_en;

    always_comb begin
        if (eye_active) begin
            pad_vpo = eye_vpo;
            pad_vmo = eye_vmo;
            driving = 1'b1;
        end else begin
            pad_vpo = tx_dp_req;
            pad_vmo = tx_dm_req;
            driving = tx_drive_req;
        end
        pad_oe_n = ~driving;
        mon_en   = ext_xcvr | mon_force;
        oe_mon   = mon_en & driving;
    end

endmodule

// File: rtl/usbfs_line_ctrl.sv
module usbfs_line_ctrl
    import usbfs_line_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_en,
    input  logic       full_speed,
    input  logic       ext_xcvr,
    input  logic       mon_force,
    input  logic       eye_en,
    input  logic       bit_tick,
    input  logic       tx_dp_req,
    input  logic       tx_dm_req,
    input  logic       tx_drive_req,
    input  logic       rx_vp,
    input  logic       rx_vm,
    output logic       pad_vpo,
    output logic       pad_vmo,
    output logic       pad_oe_n,
    output logic       oe_mon,
    output logic       eye_busy,
    output logic [1:0] line_state
);
    logic        eye_vpo, eye_vmo;
    line_state_e ls;

    usbfs_rx_sync #(.STAGES(SYNC_STAGES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_vp      (rx_vp),
        .rx_vm      (rx_vm),
        .line_state (ls)
    );

    usbfs_eye_gen u_eye (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_en    (core_en),
        .eye_en     (eye_en),
        .full_speed (full_speed),
        .bit_tick   (bit_tick),
        .eye_active (eye_busy),
        .eye_vpo    (eye_vpo),
        .eye_vmo    (eye_vmo)
    );

    usbfs_tx_mux u_tx (
        .eye_active   (eye_busy),
        .eye_vpo      (eye_vpo),
        .eye_vmo      (eye_vmo),
        .tx_dp_req    (tx_dp_req),
        .tx_dm_req    (tx_dm_req),
        .tx_drive_req (tx_drive_req),
        .ext_xcvr     (ext_xcvr),
        .mon_force    (mon_force),
        .pad_vpo      (pad_vpo),
        .pad_vmo      (pad_vmo),
        .pad_oe_n     (pad_oe_n),
        .oe_mon       (oe_mon)
    );

    assign line_state = ls;

    // R6 / R1: test running means transceiver enabled and a differential symbol
    p_eye_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eye_busy |-> (!pad_oe_n && (pad_vpo != pad_vmo)));

    // R3: monitor silent when neither enable is set
    p_mon_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_xcvr && !mon_force) |-> !oe_mon);

    // R3: an enabled monitor never reports driving while output enable is high
    p_mon_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_mon |-> !pad_oe_n);

endmodule

// File: tb/usbfs_line_ctrl_bench.sv
module usbfs_line_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n;
    logic core_en, full_speed, ext_xcvr, mon_force, eye_en, bit_tick;
    logic tx_dp_req, tx_dm_req, tx_drive_req, rx_vp, rx_vm;
    logic pad_vpo, pad_vmo, pad_oe_n, oe_mon, eye_busy;
    logic [1:0] line_state;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    usbfs_line_ctrl u_usbfs_line_ctrl (
        .clk(clk), .rst_n(rst_n), .core_en(core_en), .full_speed(full_speed),
        .ext_xcvr(ext_xcvr), .mon_force(mon_force), .eye_en(eye_en),
        .bit_tick(bit_tick), .tx_dp_req(tx_dp_req), .tx_dm_req(tx_dm_req),
        .tx_drive_req(tx_drive_req), .rx_vp(rx_vp), .rx_vm(rx_vm),
        .pad_vpo(pad_vpo), .pad_vmo(pad_vmo), .pad_oe_n(pad_oe_n),
        .oe_mon(oe_mon), .eye_busy(eye_busy), .line_state(line_state)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_pins(input string req, input logic vpo, input logic vmo, input logic oen);
        chk(req, "pins {vpo,vmo,oe_n}", {5'd0, pad_vpo, pad_vmo, pad_oe_n}, {5'd0, vpo, vmo, oen});
    endtask

    task automatic t_reset();
        rst_n = 1'b0; core_en = 0; full_speed = 1; ext_xcvr = 0; mon_force = 0;
        eye_en = 0; bit_tick = 0; tx_dp_req = 0; tx_dm_req = 0; tx_drive_req = 0;
        rx_vp = 1; rx_vm = 1;
        #9;
        chk("R5", "reset line_state", {6'd0, line_state}, 8'h00);
        chk("R6", "reset eye_busy", {7'd0, eye_busy}, 8'h00);
        chk("R1", "reset oe_n", {7'd0, pad_oe_n}, 8'h01);
        @(negedge clk); rst_n = 1'b1;
        tick(); tick();
    endtask

    task automatic t_passthrough();
        for (int i = 0; i < 8; i++) begin
            {tx_dp_req, tx_dm_req, tx_drive_req} = 3'(i);
            #1;
            chk_pins("R2", tx_dp_req, tx_dm_req, ~tx_drive_req);
        end
        tx_drive_req = 1; #1;
        chk("R1", "oe_n when driving", {7'd0, pad_oe_n}, 8'h00);
        tx_drive_req = 0; #1;
        chk("R1", "oe_n when idle", {7'd0, pad_oe_n}, 8'h01);
    endtask

    task automatic t_monitor();
        tx_drive_req = 1; ext_xcvr = 0; mon_force = 0; #1;
        chk("R3", "monitor disabled", {7'd0, oe_mon}, 8'h00);
        ext_xcvr = 1; #1;
        chk("R3", "monitor ext xcvr", {7'd0, oe_mon}, 8'h01);
        ext_xcvr = 0; mon_force = 1; #1;
        chk("R3", "monitor forced", {7'd0, oe_mon}, 8'h01);
        tx_drive_req = 0; #1;
        chk("R3", "monitor listening", {7'd0, oe_mon}, 8'h00);
    endtask

    task automatic t_line_decode();
        logic [1:0] vec [5] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01};
        logic [1:0] prev;
        rx_vp = 1; rx_vm = 1; tick(); tick(); tick();
        prev = 2'b11;
        for (int i = 0; i < 5; i++) begin
            {rx_vp, rx_vm} = vec[i];
            tick();
            chk("R5", "line_state after 1 edge", {6'd0, line_state}, {6'd0, prev});
            tick();
            chk("R4", "line_state decode", {6'd0, line_state}, {6'd0, vec[i]});
            prev = vec[i];
        end
    endtask

    task automatic t_core_disable();
        core_en = 0; eye_en = 1; full_speed = 1;
        tx_dp_req = 1; tx_dm_req = 0; tx_drive_req = 0;
        tick(); bit_tick = 1; tick(); bit_tick = 0; tick();
        chk("R10", "eye_busy with core off", {7'd0, eye_busy}, 8'h00);
        chk_pins("R10", 1'b1, 1'b0, 1'b1);
        eye_en = 0; tick();
    endtask

    // Runs one test; fs selects speed. Expected levels derived from R7.
    task automatic t_eye(input logic fs);
        logic exp_vpo;
        core_en = 1; full_speed = fs; ext_xcvr = 1; mon_force = 0;
        tx_drive_req = 0; tx_dp_req = 1; tx_dm_req = 1;
        eye_en = 1;
        tick();
        chk("R6", "eye_busy at start", {7'd0, eye_busy}, 8'h01);
        chk_pins("R7", 1'b0, 1'b1, 1'b0);
        chk("R3", "monitor during test", {7'd0, oe_mon}, 8'h01);
        tx_drive_req = 1; tx_dp_req = 0; tx_dm_req = 0;
        tick();
        chk_pins("R8", 1'b0, 1'b1, 1'b0);
        exp_vpo = 1'b0;
        for (int i = 0; i < 6; i++) begin
            bit_tick = 1; tick(); bit_tick = 0;
            exp_vpo = ~exp_vpo;
            chk_pins("R8", exp_vpo, ~exp_vpo, 1'b0);
            tick();
            chk_pins("R8", exp_vpo, ~exp_vpo, 1'b0);
        end
        eye_en = 0; tx_drive_req = 0; tx_dp_req = 1; tx_dm_req = 0;
        tick(); tick();
        chk("R9", "busy until bit edge", {7'd0, eye_busy}, 8'h01);
        chk_pins("R9", exp_vpo, ~exp_vpo, 1'b0);
        bit_tick = 1; tick(); bit_tick = 0;
        chk("R9", "busy cleared", {7'd0, eye_busy}, 8'h00);
        chk_pins("R9", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_speed_latch();
        core_en = 1; full_speed = 1; eye_en = 1; tx_drive_req = 0;
        tick();
        chk_pins("R11", 1'b0, 1'b1, 1'b0);   // FS K
        full_speed = 0;
        tick();
        chk_pins("R11", 1'b0, 1'b1, 1'b0);   // still FS K
        bit_tick = 1; tick(); bit_tick = 0;
        chk_pins("R11", 1'b1, 1'b0, 1'b0);   // FS J
        eye_en = 0; bit_tick = 1; tick(); bit_tick = 0;
        chk("R9", "busy cleared after latch test", {7'd0, eye_busy}, 8'h00);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_passthrough();
        t_monitor();
        t_line_decode();
        t_core_disable();
        t_eye(1'b1);
        tick();
        t_eye(1'b0);
        tick();
        t_speed_latch();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule